// File: doc/BRIEF.md
# Fractional-Rate SPI Serial Clock Generator

This block makes the serial clock of an SPI master from a fast reference clock. A frequency word is added to a phase accumulator on every reference cycle. Each time the running sum reaches half of the accumulator's 2048-count full scale, the clock changes level. The output rate is therefore close to f_ref × word / 2048, and fractional words are allowed. The remainder of each wrap carries into the next half period, so uneven half periods average out to the requested rate. A loop-reset option discards that remainder instead and gives equal half periods. A doubling option halves the wrap point, which doubles the rate.

Around the clock, the block sets the idle level from the clock polarity. It issues one-cycle strobes on the serial-clock edges chosen for driving and for sampling data. It also stops the clock while no slave select is active, when gating is enabled. A combinational flag reports when the word asks for a rate above the limit for synchronous input sampling. A shift register and the chip-select logic use these outputs.

Top module: `spi_accum_clkgen`

## Requirements
- R1: While rst_n is low, sclk, launch_stb and latch_stb are all 0.
- R2: With dbl_rate=0, loop_reset=0 and a word that divides 1024, sclk toggles every 1024/word active cycles. The first toggle comes on the word-th... precisely: the accumulator starts at 0 on the first active cycle, and a toggle happens on the cycle whose running sum reaches 1024.
- R3: When a sum reaches the half scale, the excess (sum − half scale) is kept in the accumulator and counts toward the next half period.
- R4: With loop_reset=1, the accumulator returns to 0 on each toggle and every half period lasts ceil(half scale / word) cycles.
- R5: dbl_rate=1 sets the half scale to 512 instead of 1024, which doubles the clock rate for the same word.
- R6: A word at or above the half scale gives a toggle on every active cycle. The excess is kept modulo the half scale.
- R7: The block is inactive when run=0, or when gate_idle=1 and sel_any=0. While inactive, sclk follows cpol from the next cycle, no strobe fires, and the accumulator and phase return to 0. The first toggle after activation therefore counts from zero.
- R8: launch_stb pulses for one cycle, together with the new sclk level, on each sclk rising edge when launch_rise=1, or on each falling edge when launch_rise=0.
- R9: latch_stb behaves in the same way, with its edge selected by latch_rise.
- R10: With gate_idle=0, the clock runs while run=1 even when sel_any=0.
- R11: async_path is 1 exactly when freq_word × REF_MHZ > SYNC_MHZ × 2048. With the defaults of 400 and 30, a word of 153 gives 0 and a word of 154 gives 1.
- R12: A word of 0 never produces a toggle or a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Transfer in progress; clock may run |
| sel_any | input | 1 | Some slave select is asserted |
| gate_idle | input | 1 | Stop the clock while sel_any is 0 |
| cpol | input | 1 | Idle level of sclk |
| launch_rise | input | 1 | 1: launch on rising edge, 0: on falling edge |
| latch_rise | input | 1 | 1: latch on rising edge, 0: on falling edge |
| dbl_rate | input | 1 | Half scale 512 instead of 1024 |
| loop_reset | input | 1 | Clear the accumulator on every toggle |
| freq_word | input | 16 | Frequency-control word |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle strobe on the launch edge |
| latch_stb | output | 1 | One-cycle strobe on the latch edge |
| async_path | output | 1 | Rate above the synchronous-sampling limit |

## Verification
A wrong accumulator value does not show until the next toggle. It appears at sclk as a half period that is off by one or more cycles, and it can take up to a full half period (1024/word cycles) to appear. So the toggle times are measured over three consecutive edges for words that leave a remainder and for words that do not. The difference between carried and discarded remainder only appears from the second or third edge onward. A wrong phase or edge selection shows in the very cycle of the edge, as a strobe that is missing, sits on the opposite edge, or lasts more than one cycle. A stale accumulator left from an earlier transfer shifts the first toggle after enabling, so every measurement starts from an idle period.

// File: rtl/spi_clkgen_pkg.sv
// Shared types for the accumulator-based SPI clock generator.
package spi_clkgen_pkg;

    // Selection of the serial-clock edge used for each data strobe
    typedef struct packed {
        logic launch_rise;  // 1: launch on rising sclk edge
        logic latch_rise;   // 1: latch on rising sclk edge
    } edge_sel_t;

endpackage

// File: rtl/spi_phase_acc.sv
// Phase accumulator. It adds freq_word to a residual on each active cycle.
// When the sum reaches the half scale (2**(ACC_W-1), or 2**(ACC_W-2) when
// doubled), it raises edge_ev and flips the phase.
// Assumes FCW_W >= ACC_W. Inactive cycles clear the residual and the phase.
module spi_phase_acc #(
    parameter int ACC_W = 11,
    parameter int FCW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             dbl_rate,
    input  logic             loop_reset,
    input  logic [FCW_W-1:0] freq_word,
    output logic             edge_ev,
    output logic             phase_nxt
);
    localparam int SUM_W = FCW_W + 1;
    localparam logic [SUM_W-1:0] HALF_N = SUM_W'(1) << (ACC_W - 1);
    localparam logic [SUM_W-1:0] HALF_D = SUM_W'(1) << (ACC_W - 2);

    logic [ACC_W-1:0] acc_q, acc_nxt;
    logic             phase_q;
    logic [SUM_W-1:0] half, mask, sum, rem;

    // Sum, wrap detection and the next residual
    always_comb begin
        half      = dbl_rate ? HALF_D : HALF_N;
        mask      = half - SUM_W'(1);
        sum       = (SUM_W'(acc_q) & mask) + SUM_W'(freq_word);
        edge_ev   = active && (sum >= half);
        rem       = (sum - half) & mask;
        phase_nxt = phase_q ^ edge_ev;
        if (!active)
            acc_nxt = '0;
        else if (edge_ev)
            acc_nxt = loop_reset ? '0 : ACC_W'(rem);
        else
            acc_nxt = ACC_W'(sum);
    end

    // Residual and phase registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            acc_q   <= acc_nxt;
            phase_q <= active ? phase_nxt : 1'b0;
        end
    end
endmodule

// File: rtl/spi_edge_strobe.sv
// Output stage. It registers sclk as cpol xor phase (cpol while inactive),
// and pulses the launch and latch strobes in the same cycle as the sclk
// edge that each one selects. Assumes edge_ev is 0 while inactive.
module spi_edge_strobe
    import spi_clkgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  logic      cpol,
    input  logic      edge_ev,
    input  logic      phase_nxt,
    input  edge_sel_t sel,
    output logic      sclk,
    output logic      launch_stb,
    output logic      latch_stb
);
    logic sclk_nxt, rise, fall;

    // Next clock level and edge direction
    always_comb begin
        sclk_nxt = active ? (cpol ^ phase_nxt) : cpol;
        rise     = edge_ev & sclk_nxt & ~sclk;
        fall     = edge_ev & ~sclk_nxt & sclk;
    end

    // Clock and strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk       <= 1'b0;
            launch_stb <= 1'b0;
            latch_stb  <= 1'b0;
        end else begin
            sclk       <= sclk_nxt;
            launch_stb <= sel.launch_rise ? rise : fall;
            latch_stb  <= sel.latch_rise  ? rise : fall;
        end
    end
endmodule

// File: rtl/spi_rate_check.sv
// Combinational comparison of the requested rate with the limit for
// synchronous input sampling: word*REF_MHZ > SYNC_MHZ*2**ACC_W.
module spi_rate_check #(
    parameter int ACC_W    = 11,
    parameter int FCW_W    = 16,
    parameter int REF_MHZ  = 400,
    parameter int SYNC_MHZ = 30
) (
    input  logic [FCW_W-1:0] freq_word,
    output logic             async_path
);
    localparam int PW = FCW_W + 32;
    localparam logic [PW-1:0] LIMIT = PW'(SYNC_MHZ) << ACC_W;

    // Rate product against the threshold
    always_comb begin
        async_path = (PW'(freq_word) * PW'(REF_MHZ)) > LIMIT;
    end
endmodule

// File: rtl/spi_accum_clkgen.sv
// Top of the SPI clock generator. It combines the phase accumulator, the
// output stage and the rate check. The clock is active while run is high and
// either gating is off or some select is asserted.
module spi_accum_clkgen
    import spi_clkgen_pkg::*;
#(
    parameter int ACC_W    = 11,
    parameter int FCW_W    = 16,
    parameter int REF_MHZ  = 400,
    parameter int SYNC_MHZ = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sel_any,
    input  logic             gate_idle,
    input  logic             cpol,
    input  logic             launch_rise,
    input  logic             latch_rise,
    input  logic             dbl_rate,
    input  logic             loop_reset,
    input  logic [FCW_W-1:0] freq_word,
    output logic             sclk,
    output logic             launch_stb,
    output logic             latch_stb,
    output logic             async_path
);
    logic      active, edge_ev, phase_nxt;
    edge_sel_t sel;

    // Enable qualification and edge selection bundle
    always_comb begin
        active          = run && (sel_any || !gate_idle);
        sel.launch_rise = launch_rise;
        sel.latch_rise  = latch_rise;
    end

    spi_phase_acc #(.ACC_W(ACC_W), .FCW_W(FCW_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .dbl_rate   (dbl_rate),
        .loop_reset (loop_reset),
        .freq_word  (freq_word),
        .edge_ev    (edge_ev),
        .phase_nxt  (phase_nxt)
    );

    spi_edge_strobe u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .cpol       (cpol),
        .edge_ev    (edge_ev),
        .phase_nxt  (phase_nxt),
        .sel        (sel),
        .sclk       (sclk),
        .launch_stb (launch_stb),
        .latch_stb  (latch_stb)
    );

    spi_rate_check #(.ACC_W(ACC_W), .FCW_W(FCW_W), .REF_MHZ(REF_MHZ),
                     .SYNC_MHZ(SYNC_MHZ)) u_rate (
        .freq_word  (freq_word),
        .async_path (async_path)
    );
endmodule

// File: rtl/spi_accum_clkgen_chk.sv
// Port-level checker for spi_accum_clkgen, attached by bind.
module spi_accum_clkgen_chk #(
    parameter int FCW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             sel_any,
    input logic             gate_idle,
    input logic             cpol,
    input logic             launch_rise,
    input logic             latch_rise,
    input logic [FCW_W-1:0] freq_word,
    input logic             sclk,
    input logic             launch_stb,
    input logic             latch_stb
);
    // R7: inactive means idle level and no strobes on the next cycle
    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && (sel_any || !gate_idle)) |=>
            (sclk == $past(cpol)) && !launch_stb && !latch_stb);

    // R8: launch strobe sits on an edge of the selected direction
    a_r8_launch_edge: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> (sclk != $past(sclk)) && (sclk == $past(launch_rise)));

    // R9: latch strobe sits on an edge of the selected direction
    a_r9_latch_edge: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |-> (sclk != $past(sclk)) && (sclk == $past(latch_rise)));

    // R8: launch strobe never lasts two cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |=> !launch_stb);

    // R12: a zero word never yields a strobe
    a_r12_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_word == '0) |=> !launch_stb && !latch_stb);
endmodule

bind spi_accum_clkgen spi_accum_clkgen_chk #(.FCW_W(FCW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .sel_any     (sel_any),
    .gate_idle   (gate_idle),
    .cpol        (cpol),
    .launch_rise (launch_rise),
    .latch_rise  (latch_rise),
    .freq_word   (freq_word),
    .sclk        (sclk),
    .launch_stb  (launch_stb),
    .latch_stb   (latch_stb)
);

// File: tb/sim_spi_accum_clkgen.sv
module sim_spi_accum_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // word, dbl_rate, loop_reset, 1st, 2nd, 3rd toggle cycle, requirement
    localparam int VEC [NV][7] = '{
        '{ 256, 0, 0, 4,  8, 12, 2},   // R2 exact division
        '{ 384, 0, 0, 3,  6,  8, 3},   // R3 remainder carried
        '{ 384, 0, 1, 3,  6,  9, 4},   // R4 remainder dropped
        '{ 256, 1, 0, 2,  4,  6, 5},   // R5 doubled rate
        '{ 100, 1, 1, 6, 12, 18, 4},   // R4 with doubling
        '{ 100, 1, 0, 6, 11, 16, 3},   // R3 with doubling
        '{1024, 0, 0, 1,  2,  3, 6},   // R6 word equals half scale
        '{3000, 0, 0, 1,  2,  3, 6}    // R6 word above half scale
    };

    logic clk = 0, rst_n = 0, run = 0, sel_any = 0, gate_idle = 0, cpol = 0;
    logic launch_rise = 1, latch_rise = 0, dbl_rate = 0, loop_reset = 0;
    logic [15:0] freq_word = 16'd256;
    logic sclk, launch_stb, latch_stb, async_path;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_accum_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .sel_any(sel_any),
        .gate_idle(gate_idle), .cpol(cpol), .launch_rise(launch_rise),
        .latch_rise(latch_rise), .dbl_rate(dbl_rate), .loop_reset(loop_reset),
        .freq_word(freq_word), .sclk(sclk), .launch_stb(launch_stb),
        .latch_stb(latch_stb), .async_path(async_path)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hold idle for two cycles, then enable the clock on a falling edge
    task automatic restart();
        @(negedge clk); run = 0;
        @(negedge clk); @(negedge clk); run = 1;
    endtask

    // Record the first three toggle cycles and count strobe mismatches
    task automatic measure(input int ncyc, output int t1, output int t2,
                           output int t3, output int serr);
        logic prev;
        int   k;
        prev = sclk; t1 = -1; t2 = -1; t3 = -1; serr = 0; k = 0;
        for (int c = 1; c <= ncyc; c++) begin
            logic tog;
            @(posedge clk); #2;
            tog = (sclk != prev);
            if (tog) begin
                k++;
                if (k == 1) t1 = c;
                if (k == 2) t2 = c;
                if (k == 3) t3 = c;
            end
            if (launch_stb != (tog && (sclk == launch_rise))) serr++;
            if (latch_stb  != (tog && (sclk == latch_rise)))  serr++;
            prev = sclk;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int t1, t2, t3, se;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1 sclk in reset", sclk, 0);
        chk("R1 launch in reset", launch_stb, 0);
        chk("R1 latch in reset", latch_stb, 0);
        @(negedge clk); rst_n = 1;

        // Table walk: toggle timing and strobe placement
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            freq_word  = 16'(VEC[i][0]);
            dbl_rate   = VEC[i][1][0];
            loop_reset = VEC[i][2][0];
            restart();
            measure(24, t1, t2, t3, se);
            chk($sformatf("R%0d first toggle w=%0d", VEC[i][6], VEC[i][0]), t1, VEC[i][3]);
            chk($sformatf("R%0d second toggle w=%0d", VEC[i][6], VEC[i][0]), t2, VEC[i][4]);
            chk($sformatf("R%0d third toggle w=%0d", VEC[i][6], VEC[i][0]), t3, VEC[i][5]);
            chk($sformatf("R8/R9 strobes w=%0d", VEC[i][0]), se, 0);
        end

        // R7: idle level follows cpol while run is low
        @(negedge clk); run = 0; cpol = 1;
        @(posedge clk); #2;
        chk("R7 idle sclk high", sclk, 1);
        chk("R7 no launch idle", launch_stb, 0);

        // R8 R9: polarity 1, launch on falling, latch on rising
        @(negedge clk);
        freq_word = 16'd256; dbl_rate = 0; loop_reset = 0;
        launch_rise = 0; latch_rise = 1;
        restart();
        repeat (4) @(posedge clk);
        #2;
        chk("R8 falling edge sclk", sclk, 0);
        chk("R8 launch on falling", launch_stb, 1);
        chk("R9 no latch on falling", latch_stb, 0);
        repeat (4) @(posedge clk);
        #2;
        chk("R9 latch on rising", latch_stb, 1);
        chk("R8 no launch on rising", launch_stb, 0);

        // R10: gating with no select holds the clock
        @(negedge clk); cpol = 0; launch_rise = 1; latch_rise = 0;
        gate_idle = 1; sel_any = 0;
        restart();
        measure(30, t1, t2, t3, se);
        chk("R10 gated no toggle", t1, -1);
        chk("R10 gated sclk idle", sclk, 0);
        @(negedge clk); sel_any = 1;
        measure(8, t1, t2, t3, se);
        chk("R7 first toggle after ungating", t1, 4);
        @(negedge clk); gate_idle = 0; sel_any = 0;
        restart();
        measure(8, t1, t2, t3, se);
        chk("R10 ungated runs without select", t1, 4);

        // R12: zero word never toggles
        @(negedge clk); freq_word = 16'd0;
        restart();
        measure(60, t1, t2, t3, se);
        chk("R12 zero word no toggle", t1, -1);
        chk("R12 zero word no strobe", se, 0);

        // R11: rate threshold around 153.6
        @(negedge clk); run = 0; freq_word = 16'd153;
        #1; chk("R11 word 153 sync", async_path, 0);
        freq_word = 16'd154;
        #1; chk("R11 word 154 async", async_path, 1);
        freq_word = 16'hFFFF;
        #1; chk("R11 max word async", async_path, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule